// File: doc/BRIEF.md
# Sliced 16-bit Arithmetic and Logic Unit

This block is a purely combinational arithmetic and logic unit for a 16-bit datapath. It takes two operands, a 3-bit result select, separate invert controls for each operand and a carry-in. From these it returns a 16-bit result, a zero flag and a carry-out. The datapath is split into four identical 4-bit slices. Each slice holds a 4-bit carry-lookahead adder and the bitwise AND, OR, NOR and XOR functions. The carry-out of each slice drives the carry-in of the slice above it.

Subtraction has no opcode of its own. The caller selects the adder and sets one invert control together with carry-in, which forms the two's complement of that operand. Inverting B gives A minus B. Inverting A gives B minus A.

The zero flag is the NOR of all result bits, so a branch comparison can be made from a subtraction. The block has no clock and no reset. Its outputs follow its inputs after the combinational delay.

Top module: `sliced_alu`

## Requirements
- R1: With select 000 the result is X + Y + cin modulo 2^16. Here X is the A operand, bitwise inverted when the A-invert control is 1, and Y is the B operand, bitwise inverted when the B-invert control is 1. The carry-out is bit 16 of that sum.
- R2: With select 000 and all three controls at 0, the result is A + B modulo 2^16 and the carry-out is the unsigned overflow of that addition.
- R3: With select 000, B-invert 1, A-invert 0 and carry-in 1, the result is A − B modulo 2^16. The carry-out is 1 exactly when A ≥ B as unsigned values.
- R4: With select 000, A-invert 1, B-invert 0 and carry-in 1, the result is B − A modulo 2^16. The carry-out is 1 exactly when B ≥ A.
- R5: With select 001 the result is X AND Y. Both operands are conditioned by their invert controls.
- R6: With select 010 the result is X OR Y.
- R7: With select 011 the result is NOT (X OR Y).
- R8: With select 100 the result is X XOR Y.
- R9: For selects other than 000, carry-in has no effect on the result and the carry-out is 0.
- R10: Selects 101, 110 and 111 give an all-zero result, a carry-out of 0 and a zero flag of 1.
- R11: The zero flag is 1 exactly when all 16 result bits are 0, for every select.
- R12: Carries propagate across slice boundaries. For example, 0x0FFF + 1 = 0x1000, and 0xFFFF + 1 gives result 0 with carry-out 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| opa_i | input | 16 | Operand A |
| opb_i | input | 16 | Operand B |
| sel_i | input | 3 | Result select (000 adder, 001 AND, 010 OR, 011 NOR, 100 XOR) |
| inv_a_i | input | 1 | Bitwise invert of operand A before every function |
| inv_b_i | input | 1 | Bitwise invert of operand B before every function |
| cin_i | input | 1 | Carry into the lowest slice |
| res_o | output | 16 | Result |
| zero_o | output | 1 | High when every result bit is 0 |
| cout_o | output | 1 | Carry out of the top slice (0 unless select is 000) |

## Verification
The zero flag and the carry-out can both rise on the same vector. This happens when an addition wraps to exactly zero, for example 0xFFFF + 0x0001. It also happens when a subtraction of equal operands produces zero with no borrow. Directed tasks apply these cases, plus equal-operand subtraction in both directions. Each output is judged against a reference computed in the bench from integer arithmetic. Random vectors over every select and invert combination then confirm that neither flag is dropped or raised when only the other one should change.

// File: rtl/sliced_alu_pkg.sv
package sliced_alu_pkg;

  // Result select encodings; the order is decoded by every slice.
  typedef enum logic [2:0] {
    OP_SUM = 3'b000,
    OP_AND = 3'b001,
    OP_OR  = 3'b010,
    OP_NOR = 3'b011,
    OP_XOR = 3'b100
  } alu_op_e;

  localparam int unsigned SEL_W = 3;

endpackage

// File: rtl/alu_cla.sv
// Carry-lookahead adder of parameterised width: every internal carry is a
// two-level sum of products over generate/propagate terms and carry-in.
module alu_cla #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] x_i,
  input  logic [W-1:0] y_i,
  input  logic         c_i,
  output logic [W-1:0] s_o,
  output logic         c_o
);

  logic [W-1:0] gen;
  logic [W-1:0] prop;
  logic [W:0]   cry;

  assign gen  = x_i & y_i;
  assign prop = x_i ^ y_i;

  always_comb begin
    cry[0] = c_i;
    for (int i = 0; i < W; i++) begin
      logic acc;
      logic pchain;
      acc    = gen[i];
      pchain = prop[i];
      for (int j = i - 1; j >= 0; j--) begin
        acc    = acc | (pchain & gen[j]);
        pchain = pchain & prop[j];
      end
      cry[i+1] = acc | (pchain & c_i);
    end
  end

  assign s_o = prop ^ cry[W-1:0];
  assign c_o = cry[W];

endmodule

// File: rtl/alu_slice.sv
// One slice: operand conditioning, lookahead adder, bitwise functions, select.
module alu_slice
  import sliced_alu_pkg::*;
#(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0]     a_i,
  input  logic [W-1:0]     b_i,
  input  logic [SEL_W-1:0] sel_i,
  input  logic             inv_a_i,
  input  logic             inv_b_i,
  input  logic             c_i,
  output logic [W-1:0]     y_o,
  output logic             c_o
);

  logic [W-1:0] xa;
  logic [W-1:0] yb;
  logic [W-1:0] sum;

  assign xa = inv_a_i ? ~a_i : a_i;
  assign yb = inv_b_i ? ~b_i : b_i;

  alu_cla #(.W(W)) u_cla (
    .x_i (xa),
    .y_i (yb),
    .c_i (c_i),
    .s_o (sum),
    .c_o (c_o)
  );

  always_comb begin
    case (sel_i)
      OP_SUM:  y_o = sum;
      OP_AND:  y_o = xa & yb;
      OP_OR:   y_o = xa | yb;
      OP_NOR:  y_o = ~(xa | yb);
      OP_XOR:  y_o = xa ^ yb;
      default: y_o = '0;
    endcase
  end

endmodule

// File: rtl/sliced_alu.sv
// Top: identical slices chained through their carries, zero detect, carry gate.
module sliced_alu
  import sliced_alu_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned SLICE_W = 4
) (
  input  logic [DATA_W-1:0] opa_i,
  input  logic [DATA_W-1:0] opb_i,
  input  logic [2:0]        sel_i,
  input  logic              inv_a_i,
  input  logic              inv_b_i,
  input  logic              cin_i,
  output logic [DATA_W-1:0] res_o,
  output logic              zero_o,
  output logic              cout_o
);

  localparam int unsigned NUM_SLICES = DATA_W / SLICE_W;

  logic [NUM_SLICES:0] chain;

  assign chain[0] = cin_i;

  for (genvar s = 0; s < NUM_SLICES; s++) begin : g_slice
    alu_slice #(.W(SLICE_W)) u_slice (
      .a_i     (opa_i[s*SLICE_W +: SLICE_W]),
      .b_i     (opb_i[s*SLICE_W +: SLICE_W]),
      .sel_i   (sel_i),
      .inv_a_i (inv_a_i),
      .inv_b_i (inv_b_i),
      .c_i     (chain[s]),
      .y_o     (res_o[s*SLICE_W +: SLICE_W]),
      .c_o     (chain[s+1])
    );
  end

  assign zero_o = ~|res_o;
  assign cout_o = (sel_i == OP_SUM) ? chain[NUM_SLICES] : 1'b0;

endmodule

// File: rtl/sliced_alu_chk.sv
module sliced_alu_chk #(
  parameter int unsigned DATA_W = 16
) (
  input logic [DATA_W-1:0] opa_i,
  input logic [DATA_W-1:0] opb_i,
  input logic [2:0]        sel_i,
  input logic              inv_a_i,
  input logic              inv_b_i,
  input logic              cin_i,
  input logic [DATA_W-1:0] res_o,
  input logic              zero_o,
  input logic              cout_o
);

  logic [DATA_W:0]   plain_sum;
  logic [DATA_W-1:0] cx;
  logic [DATA_W-1:0] cy;

  assign plain_sum = (DATA_W+1)'(opa_i) + (DATA_W+1)'(opb_i);
  assign cx = inv_a_i ? ~opa_i : opa_i;
  assign cy = inv_b_i ? ~opb_i : opb_i;

  always_comb begin
    if (sel_i == 3'b000 && !inv_a_i && !inv_b_i && !cin_i)
      AST_ADD_SUM: assert ({cout_o, res_o} == plain_sum) else $error("add mismatch"); // R2
    if (sel_i == 3'b000 && !inv_a_i && inv_b_i && cin_i)
      AST_SUB_AB: assert (res_o == opa_i - opb_i && cout_o == (opa_i >= opb_i)) else $error("a-b mismatch"); // R3
    if (sel_i == 3'b000 && inv_a_i && !inv_b_i && cin_i)
      AST_SUB_BA: assert (res_o == opb_i - opa_i && cout_o == (opb_i >= opa_i)) else $error("b-a mismatch"); // R4
    if (sel_i == 3'b001)
      AST_AND_FN: assert (res_o == (cx & cy)) else $error("and mismatch"); // R5
    if (sel_i == 3'b100)
      AST_XOR_FN: assert (res_o == (cx ^ cy)) else $error("xor mismatch"); // R8
    if (sel_i != 3'b000)
      AST_LOGIC_NO_CARRY: assert (!cout_o) else $error("carry out on logic op"); // R9
    if (sel_i > 3'b100)
      AST_RESERVED_ZERO: assert (res_o == '0 && zero_o) else $error("reserved select not zero"); // R10
    AST_ZERO_FLAG: assert (zero_o == (res_o == '0)) else $error("zero flag mismatch"); // R11
  end

endmodule

bind sliced_alu sliced_alu_chk #(.DATA_W(DATA_W)) u_chk (
  .opa_i   (opa_i),
  .opb_i   (opb_i),
  .sel_i   (sel_i),
  .inv_a_i (inv_a_i),
  .inv_b_i (inv_b_i),
  .cin_i   (cin_i),
  .res_o   (res_o),
  .zero_o  (zero_o),
  .cout_o  (cout_o)
);

// File: tb/sim_sliced_alu.sv
`timescale 1ns/1ps
module sim_sliced_alu;

  logic        clk = 1'b0;
  logic [15:0] opa, opb;
  logic [2:0]  sel;
  logic        ia, ib, ci;
  logic [15:0] res;
  logic        zero, cout;

  int n_vec  = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sliced_alu u0 (
    .opa_i (opa), .opb_i (opb), .sel_i (sel),
    .inv_a_i (ia), .inv_b_i (ib), .cin_i (ci),
    .res_o (res), .zero_o (zero), .cout_o (cout)
  );

  // Reference built from the requirement text.
  task automatic expect_of(input logic [15:0] a, input logic [15:0] b, input logic [2:0] s,
                           input logic xa_n, input logic yb_n, input logic c,
                           output logic [15:0] er, output logic ec, output logic ez);
    logic [15:0] x, y;
    logic [16:0] full;
    x = xa_n ? ~a : a;
    y = yb_n ? ~b : b;
    ec = 1'b0;
    case (s)
      3'd0: begin full = {1'b0, x} + {1'b0, y} + {16'd0, c}; er = full[15:0]; ec = full[16]; end
      3'd1: er = x & y;
      3'd2: er = x | y;
      3'd3: er = ~(x | y);
      3'd4: er = x ^ y;
      default: er = 16'd0;
    endcase
    ez = (er == 16'd0);
  endtask

  task automatic vec(input string rq, input logic [15:0] a, input logic [15:0] b,
                     input logic [2:0] s, input logic xa_n, input logic yb_n, input logic c);
    logic [15:0] er;
    logic ec, ez;
    @(negedge clk);
    opa = a; opb = b; sel = s; ia = xa_n; ib = yb_n; ci = c;
    #1;
    expect_of(a, b, s, xa_n, yb_n, c, er, ec, ez);
    n_vec++;
    if (res !== er || cout !== ec || zero !== ez) begin
      n_fail++;
      $display("FAIL %s: a=%h b=%h sel=%0d ia=%b ib=%b ci=%b got res=%h cout=%b zero=%b exp res=%h cout=%b zero=%b",
               rq, a, b, s, xa_n, yb_n, c, res, cout, zero, er, ec, ez);
    end
  endtask

  task automatic t_idle_state;
    vec("R11", 16'h0000, 16'h0000, 3'd0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic t_add;   // R2 R1
    vec("R2", 16'h1234, 16'h4321, 3'd0, 0, 0, 0);
    vec("R2", 16'h8000, 16'h8000, 3'd0, 0, 0, 0);
    vec("R1", 16'h00FF, 16'h0F00, 3'd0, 0, 0, 1);
    vec("R1", 16'hA5A5, 16'h5A5A, 3'd0, 1, 1, 1);
  endtask

  task automatic t_sub;   // R3 R4
    vec("R3", 16'h0100, 16'h0001, 3'd0, 0, 1, 1);
    vec("R3", 16'h0001, 16'h0100, 3'd0, 0, 1, 1);
    vec("R3", 16'h7777, 16'h7777, 3'd0, 0, 1, 1);
    vec("R4", 16'h0005, 16'h0009, 3'd0, 1, 0, 1);
    vec("R4", 16'h0009, 16'h0005, 3'd0, 1, 0, 1);
    vec("R4", 16'hFFFF, 16'hFFFF, 3'd0, 1, 0, 1);
  endtask

  task automatic t_logic; // R5 R6 R7 R8
    vec("R5", 16'hF0F0, 16'hFF00, 3'd1, 0, 0, 0);
    vec("R5", 16'hF0F0, 16'hFF00, 3'd1, 1, 0, 0);
    vec("R6", 16'h0F0F, 16'h00F0, 3'd2, 0, 0, 0);
    vec("R6", 16'h0F0F, 16'h00F0, 3'd2, 0, 1, 0);
    vec("R7", 16'h0F0F, 16'h00F0, 3'd3, 0, 0, 0);
    vec("R7", 16'h0000, 16'h0000, 3'd3, 0, 0, 0);
    vec("R8", 16'hAAAA, 16'hAAAA, 3'd4, 0, 0, 0);
    vec("R8", 16'hAAAA, 16'h5555, 3'd4, 1, 1, 0);
  endtask

  task automatic t_cin_ignored; // R9
    for (int s = 1; s < 5; s++) begin
      vec("R9", 16'hFFFF, 16'hFFFF, 3'(s), 0, 0, 1);
      vec("R9", 16'h1357, 16'h2468, 3'(s), 0, 0, 1);
    end
  endtask

  task automatic t_reserved; // R10
    for (int s = 5; s < 8; s++) begin
      vec("R10", 16'hFFFF, 16'h0001, 3'(s), 0, 0, 1);
      vec("R10", 16'h1234, 16'hABCD, 3'(s), 1, 1, 0);
    end
  endtask

  task automatic t_carry_chain; // R12
    vec("R12", 16'h0FFF, 16'h0001, 3'd0, 0, 0, 0);
    vec("R12", 16'h00FF, 16'h0000, 3'd0, 0, 0, 1);
    vec("R12", 16'hFFFF, 16'h0001, 3'd0, 0, 0, 0);
    vec("R12", 16'hFFFF, 16'h0000, 3'd0, 0, 0, 1);
    vec("R12", 16'h0000, 16'h0001, 3'd0, 0, 1, 1);
  endtask

  task automatic t_random; // R1 R5 R6 R7 R8 R10 R11
    for (int k = 0; k < 3000; k++) begin
      logic [15:0] a, b;
      logic [4:0] ctl;
      a = 16'($urandom);
      b = 16'($urandom);
      ctl = 5'($urandom);
      if (k % 7 == 0) b = a;
      vec("R1/R11 random", a, b, 3'(k % 8), ctl[0], ctl[1], ctl[2]);
    end
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      n_fail++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    opa = '0; opb = '0; sel = '0; ia = 0; ib = 0; ci = 0;
    repeat (2) @(posedge clk);
    t_idle_state();
    t_add();
    t_sub();
    t_logic();
    t_cin_ignored();
    t_reserved();
    t_carry_chain();
    t_random();
    finished = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
    $finish;
  end

endmodule